// File: doc/BRIEF.md
# Two-Stage Segment and Page Address Translator

This block turns a 24-bit virtual address into a 24-bit physical address in two chained lookups. The upper four bits choose a segment descriptor. The descriptor holds the segment's bound, its read and write rights, and a slot number that picks one of several page tables. The next eight bits then choose an entry in that page table. The entry supplies a 12-bit frame number, a residency flag, a write right and a flag that makes the page visible to user mode. The frame number is placed in front of the untouched 12-bit offset. No adder is used anywhere on the page path.

A requester presents an address, a read/write flag and a user/kernel flag under a valid/ready handshake. One cycle after the request is accepted, the block returns either a physical address or a 3-bit fault code. On a fault the returned address is zero. Descriptors and page entries live in internal registers. These are loaded through a single write port. The write port takes priority over translation: while it writes, the block does not accept requests. Reset marks every descriptor and every page entry invalid.

Top module: `seg_page_xlate`

## Requirements
- R1: After reset, rsp_valid_o is 0, req_ready_o is 1, and every segment and page entry is invalid. A first request therefore returns fault code 1.
- R2: req_ready_o equals the inverse of cfg_we_i. A request is accepted on a rising edge where req_valid_i and req_ready_o are both 1. rsp_valid_o is 1 in exactly the cycle after each acceptance and 0 otherwise.
- R3: With no fault, rsp_paddr_o = {page frame number, vaddr[11:0]} and rsp_fault_o = 0.
- R4: When the segment entry is invalid, or the page number vaddr[19:12] is greater than the segment limit, the fault code is 1. A page number equal to the limit passes this check.
- R5: A read to a segment without read right, or a write to a segment without write right, gives fault code 2.
- R6: When the selected page entry's valid bit is clear, the fault code is 3.
- R7: A write to a page without write right gives fault code 4, in either privilege mode.
- R8: A user-mode access (req_user_i=1) to a page not marked user-visible gives fault code 5. The same access in kernel mode translates normally.
- R9: When several faults apply, the lowest-numbered check wins: limit (1), then segment right (2), then not present (3), then page write (4), then user visibility (5).
- R10: Write port format. With cfg_sel_i=0, the port writes segment entry cfg_idx_i[3:0]. Its fields are: data[7:0] limit, data[9:8] page-table slot, data[12] read right, data[13] write right, data[14] valid. With cfg_sel_i=1, the port writes the page entry of slot cfg_idx_i[9:8] and page cfg_idx_i[7:0]. Its fields are: data[11:0] frame, data[12] user-visible, data[13] write right, data[14] valid. A request accepted in the cycle after the write sees the new entry. The page entry used for a translation is {slot of the segment, vaddr[19:12]}.
- R11: Whenever rsp_fault_o is nonzero, rsp_paddr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_vaddr_i | input | 24 | Virtual address: segment, page, offset |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| req_user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| rsp_valid_o | output | 1 | Result valid |
| rsp_paddr_o | output | 24 | Physical address, zero on fault |
| rsp_fault_o | output | 3 | Fault code, 0 = none |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_sel_i | input | 1 | 0 = segment entry, 1 = page entry |
| cfg_idx_i | input | 10 | Entry index |
| cfg_data_i | input | 15 | Entry contents |

## Verification
Requests are issued back to back against segments that differ in one attribute at a time: read-only, write-only, narrow limit, and different page-table slots. Each fault code is therefore separated from its neighbours, and the slot selection is shown to route to distinct tables. Some addresses break several rules at once to expose the check order. Others sit exactly on the limit, which separates an inclusive bound from an exclusive one. Paired kernel and user accesses to the same page tell the visibility check apart from the write check. A descriptor is rewritten while a request is held, which exercises the stall on the write port and the use of the new contents on the next cycle.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int SEG_W_D  = 4;
  localparam int VPN_W_D  = 8;
  localparam int OFF_W_D  = 12;
  localparam int PFN_W_D  = 12;
  localparam int SLOT_W_D = 2;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_LIMIT     = 3'd1,
    FLT_SEG_PROT  = 3'd2,
    FLT_ABSENT    = 3'd3,
    FLT_PAGE_PROT = 3'd4,
    FLT_USER      = 3'd5
  } fault_e;
endpackage

// File: rtl/xlate_seg_table.sv
module xlate_seg_table #(
  parameter int SEG_W = 4,
  parameter int ENT_W = 13,
  localparam int N    = 1 << SEG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEG_W-1:0] wr_idx_i,
  input  logic [ENT_W-1:0] wr_ent_i,
  input  logic [SEG_W-1:0] rd_idx_i,
  output logic [ENT_W-1:0] rd_ent_o
);
  logic [ENT_W-1:0] ent_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ent_q[g] <= '0;
      else if (we_i && wr_idx_i == SEG_W'(g))   ent_q[g] <= wr_ent_i;
    end
  end

  assign rd_ent_o = ent_q[rd_idx_i];
endmodule

// File: rtl/xlate_page_pool.sv
module xlate_page_pool #(
  parameter int IDX_W = 10,
  parameter int PAY_W = 14,
  localparam int N    = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  logic [PAY_W-1:0] wr_pay_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [PAY_W-1:0] rd_pay_o
);
  logic [N-1:0]     valid_q;
  logic [PAY_W-1:0] pay_q [N];

  // only residency needs reset; payload is don't-care while invalid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   valid_q <= '0;
    else if (we_i) valid_q[wr_idx_i] <= wr_valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) pay_q[wr_idx_i] <= wr_pay_i;
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_pay_o   = pay_q[rd_idx_i];
endmodule

// File: rtl/xlate_fault_eval.sv
module xlate_fault_eval
  import xlate_pkg::*;
#(
  parameter int VPN_W = 8,
  parameter int OFF_W = 12,
  parameter int PFN_W = 12,
  localparam int PA_W = PFN_W + OFF_W
) (
  input  logic             seg_valid_i,
  input  logic             seg_rd_i,
  input  logic             seg_wr_i,
  input  logic [VPN_W-1:0] seg_limit_i,
  input  logic             pg_valid_i,
  input  logic             pg_wr_i,
  input  logic             pg_user_i,
  input  logic [PFN_W-1:0] pg_pfn_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             write_i,
  input  logic             user_i,
  output fault_e           fault_o,
  output logic [PA_W-1:0]  paddr_o
);
  always_comb begin
    if (!seg_valid_i || vpn_i > seg_limit_i)       fault_o = FLT_LIMIT;
    else if (write_i ? !seg_wr_i : !seg_rd_i)      fault_o = FLT_SEG_PROT;
    else if (!pg_valid_i)                          fault_o = FLT_ABSENT;
    else if (write_i && !pg_wr_i)                  fault_o = FLT_PAGE_PROT;
    else if (user_i && !pg_user_i)                 fault_o = FLT_USER;
    else                                           fault_o = FLT_NONE;
  end

  // frame substitution only, no arithmetic
  assign paddr_o = (fault_o == FLT_NONE) ? {pg_pfn_i, off_i} : '0;
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import xlate_pkg::*;
#(
  parameter int SEG_W    = SEG_W_D,
  parameter int VPN_W    = VPN_W_D,
  parameter int OFF_W    = OFF_W_D,
  parameter int PFN_W    = PFN_W_D,
  parameter int SLOT_W   = SLOT_W_D,
  localparam int VA_W    = SEG_W + VPN_W + OFF_W,
  localparam int PA_W    = PFN_W + OFF_W,
  localparam int PG_IX_W = SLOT_W + VPN_W,
  localparam int IDX_W   = (SEG_W > PG_IX_W) ? SEG_W : PG_IX_W,
  localparam int FLD     = (PFN_W > PG_IX_W) ? PFN_W : PG_IX_W,
  localparam int CFG_W   = FLD + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  input  logic             req_user_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic [2:0]       rsp_fault_o,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [CFG_W-1:0] cfg_data_i
);
  localparam int SEG_E_W = PG_IX_W + 3;
  localparam int PAY_W   = PFN_W + 2;

  logic [SEG_W-1:0] va_seg;
  logic [VPN_W-1:0] va_vpn;
  logic [OFF_W-1:0] va_off;
  assign {va_seg, va_vpn, va_off} = req_vaddr_i;

  // seg entry: {valid, wr, rd, slot, limit}
  logic [SEG_E_W-1:0] seg_wr_ent, seg_ent;
  assign seg_wr_ent = {cfg_data_i[FLD+2], cfg_data_i[FLD+1], cfg_data_i[FLD],
                       cfg_data_i[PG_IX_W-1:0]};

  xlate_seg_table #(.SEG_W(SEG_W), .ENT_W(SEG_E_W)) u_seg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i && !cfg_sel_i),
    .wr_idx_i (cfg_idx_i[SEG_W-1:0]),
    .wr_ent_i (seg_wr_ent),
    .rd_idx_i (va_seg),
    .rd_ent_o (seg_ent)
  );

  logic              seg_valid, seg_wr, seg_rd;
  logic [SLOT_W-1:0] seg_slot;
  logic [VPN_W-1:0]  seg_limit;
  assign {seg_valid, seg_wr, seg_rd, seg_slot, seg_limit} = seg_ent;

  // page entry payload: {wr, user, pfn}
  logic             pg_valid;
  logic [PAY_W-1:0] pg_pay;
  logic             pg_wr, pg_user;
  logic [PFN_W-1:0] pg_pfn;

  xlate_page_pool #(.IDX_W(PG_IX_W), .PAY_W(PAY_W)) u_pool (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i && cfg_sel_i),
    .wr_idx_i   (cfg_idx_i[PG_IX_W-1:0]),
    .wr_valid_i (cfg_data_i[FLD+2]),
    .wr_pay_i   ({cfg_data_i[FLD+1], cfg_data_i[FLD], cfg_data_i[PFN_W-1:0]}),
    .rd_idx_i   ({seg_slot, va_vpn}),
    .rd_valid_o (pg_valid),
    .rd_pay_o   (pg_pay)
  );
  assign {pg_wr, pg_user, pg_pfn} = pg_pay;

  fault_e          fault_d;
  logic [PA_W-1:0] paddr_d;

  xlate_fault_eval #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W)) u_eval (
    .seg_valid_i (seg_valid),
    .seg_rd_i    (seg_rd),
    .seg_wr_i    (seg_wr),
    .seg_limit_i (seg_limit),
    .pg_valid_i  (pg_valid),
    .pg_wr_i     (pg_wr),
    .pg_user_i   (pg_user),
    .pg_pfn_i    (pg_pfn),
    .vpn_i       (va_vpn),
    .off_i       (va_off),
    .write_i     (req_write_i),
    .user_i      (req_user_i),
    .fault_o     (fault_d),
    .paddr_o     (paddr_d)
  );

  // table writes win over translation
  assign req_ready_o = !cfg_we_i;

  logic accept;
  assign accept = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_fault_o <= FLT_NONE;
    end else begin
      rsp_valid_o <= accept;
      if (accept) begin
        rsp_paddr_o <= paddr_d;
        rsp_fault_o <= fault_d;
      end
    end
  end
endmodule

// File: rtl/seg_page_xlate_sva.sv
module seg_page_xlate_sva #(
  parameter int OFF_W = 12,
  parameter int PA_W  = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [OFF_W-1:0] req_off_i,
  input logic             req_write_i,
  input logic             req_user_i,
  input logic             rsp_valid_o,
  input logic [PA_W-1:0]  rsp_paddr_o,
  input logic [2:0]       rsp_fault_o,
  input logic             cfg_we_i
);
  assert_rsp_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !rsp_valid_o);

  assert_write_port_stalls_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |-> !req_ready_o);

  assert_offset_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=>
      (rsp_fault_o != 3'd0 || rsp_paddr_o[OFF_W-1:0] == $past(req_off_i)));

  assert_read_no_page_prot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !req_write_i) |=> rsp_fault_o != 3'd4);

  assert_kernel_sees_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !req_user_i) |=> rsp_fault_o != 3'd5);

  assert_fault_code_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_fault_o <= 3'd5);

  assert_fault_zero_addr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != 3'd0) |-> rsp_paddr_o == '0);
endmodule

bind seg_page_xlate seg_page_xlate_sva #(.OFF_W(OFF_W), .PA_W(PA_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_off_i   (req_vaddr_i[OFF_W-1:0]),
  .req_write_i (req_write_i),
  .req_user_i  (req_user_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_fault_o (rsp_fault_o),
  .cfg_we_i    (cfg_we_i)
);

// File: tb/seg_page_xlate_bench.sv
`timescale 1ns/1ps
module seg_page_xlate_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [23:0] req_vaddr_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_user_i = 1'b0;
  logic        rsp_valid_o;
  logic [23:0] rsp_paddr_o;
  logic [2:0]  rsp_fault_o;
  logic        cfg_we_i = 1'b0;
  logic        cfg_sel_i = 1'b0;
  logic [9:0]  cfg_idx_i = '0;
  logic [14:0] cfg_data_i = '0;

  always #2.5 clk_i = ~clk_i;

  seg_page_xlate u_seg_page_xlate (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural model state
  logic [14:0] seg_m [16];
  logic [14:0] pg_m  [1024];
  bit          exp_v = 0;
  int          exp_f = 0;
  logic [23:0] exp_pa = '0;
  string       exp_tag = "";
  string       cur_tag = "";

  function automatic string tag_of(int f);
    case (f)
      0: return "R3";  1: return "R4";  2: return "R5";
      3: return "R6";  4: return "R7";  default: return "R8";
    endcase
  endfunction

  function automatic logic [14:0] seg_word(bit v, bit rd, bit wr, int slot, int lim);
    logic [14:0] w;
    w = '0;
    w[14] = v; w[13] = wr; w[12] = rd;
    w[9:8] = 2'(slot); w[7:0] = 8'(lim);
    return w;
  endfunction

  function automatic logic [14:0] pg_word(bit v, bit wr, bit usr, int pfn);
    logic [14:0] w;
    w = '0;
    w[14] = v; w[13] = wr; w[12] = usr; w[11:0] = 12'(pfn);
    return w;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_v = 0;
      foreach (seg_m[i]) seg_m[i] = '0;
      foreach (pg_m[i])  pg_m[i]  = '0;
    end else begin
      exp_v = req_valid_i && !cfg_we_i;
      if (exp_v) begin
        int s, p, o, si;
        logic [14:0] se, pe;
        s  = int'(req_vaddr_i[23:20]);
        p  = int'(req_vaddr_i[19:12]);
        o  = int'(req_vaddr_i[11:0]);
        se = seg_m[s];
        si = int'(se[9:8]) * 256 + p;
        pe = pg_m[si];
        if (!se[14] || p > int'(se[7:0]))      exp_f = 1;
        else if (req_write_i ? !se[13] : !se[12]) exp_f = 2;
        else if (!pe[14])                        exp_f = 3;
        else if (req_write_i && !pe[13])         exp_f = 4;
        else if (req_user_i && !pe[12])          exp_f = 5;
        else                                     exp_f = 0;
        exp_pa  = (exp_f == 0) ? {pe[11:0], 12'(o)} : 24'h0;
        exp_tag = (cur_tag != "") ? cur_tag : tag_of(exp_f);
      end
      if (cfg_we_i) begin
        if (cfg_sel_i) pg_m[cfg_idx_i] = cfg_data_i;
        else           seg_m[cfg_idx_i[3:0]] = cfg_data_i;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      n_chk++;
      if (rsp_valid_o !== exp_v) begin
        n_fail++;
        $display("FAIL R2 rsp_valid actual=%0b expected=%0b", rsp_valid_o, exp_v);
      end
      if (exp_v) begin
        n_chk++;
        if (int'(rsp_fault_o) != exp_f) begin
          n_fail++;
          $display("FAIL %s fault actual=%0d expected=%0d", exp_tag, rsp_fault_o, exp_f);
        end
        n_chk++;
        if (rsp_paddr_o !== exp_pa) begin
          n_fail++;
          $display("FAIL %s paddr actual=%h expected=%h",
                   (exp_f == 0) ? exp_tag : "R11", rsp_paddr_o, exp_pa);
        end
      end
    end
  end

  task automatic check1(string tag, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic issue(int seg, int vpn, int off, bit wr, bit usr, string tag = "");
    req_valid_i = 1'b1;
    req_vaddr_i = {4'(seg), 8'(vpn), 12'(off)};
    req_write_i = wr;
    req_user_i  = usr;
    cur_tag     = tag;
    @(negedge clk_i);
  endtask

  task automatic idle();
    req_valid_i = 1'b0;
    cur_tag = "";
    @(negedge clk_i);
  endtask

  task automatic cfg(bit sel, int idx, logic [14:0] data);
    cfg_we_i   = 1'b1;
    cfg_sel_i  = sel;
    cfg_idx_i  = 10'(idx);
    cfg_data_i = data;
    #1;
    check1("R2 ready during write", int'(req_ready_o), 0);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check1("R1 rsp_valid after reset", int'(rsp_valid_o), 0);
    check1("R1 ready after reset", int'(req_ready_o), 1);
    issue(0, 0, 12'h010, 0, 0, "R1");
    issue(5, 3, 12'h020, 1, 1, "R1");
    idle();

    // R10: load tables through the write port
    cfg(0, 1, seg_word(1, 1, 1, 2, 8'h10));
    cfg(0, 2, seg_word(1, 1, 0, 1, 8'hFF));
    cfg(0, 3, seg_word(1, 0, 1, 0, 8'h05));
    cfg(1, 2*256 + 3, pg_word(1, 1, 1, 12'hABC));
    cfg(1, 2*256 + 4, pg_word(1, 0, 1, 12'h123));
    cfg(1, 2*256 + 5, pg_word(1, 1, 0, 12'h456));
    cfg(1, 2*256 + 7, pg_word(1, 0, 0, 12'h999));
    cfg(1, 2*256 + 16, pg_word(0, 1, 1, 12'hEEE));
    cfg(1, 1*256 + 8'h80, pg_word(1, 1, 1, 12'h777));
    cfg(1, 0*256 + 2, pg_word(1, 1, 1, 12'h321));
    cfg(1, 1*256 + 3, pg_word(1, 1, 1, 12'h5C5));

    // back-to-back main traffic
    issue(1, 3, 12'h5A5, 0, 1);
    issue(1, 3, 12'hFFF, 1, 1);
    issue(1, 3, 12'h000, 1, 0);
    issue(1, 8'h11, 12'h001, 0, 0);          // one past limit
    issue(1, 8'h10, 12'h002, 0, 0, "R4");    // at limit, passes bound, not present
    issue(1, 4, 12'h0F0, 1, 1);
    issue(1, 4, 12'h0F0, 1, 0);              // kernel write to read-only page
    issue(1, 4, 12'h0F1, 0, 1);
    issue(1, 5, 12'h333, 0, 1);
    issue(1, 5, 12'h333, 0, 0, "R8");        // kernel reaches hidden page
    issue(1, 6, 12'h444, 0, 0);
    idle();
    issue(2, 8'h80, 12'h777, 1, 0);
    issue(2, 8'h80, 12'h778, 0, 1);
    issue(2, 3, 12'h010, 0, 0, "R10");       // slot 1, not slot 2
    issue(3, 2, 12'h111, 0, 0);
    issue(3, 2, 12'h222, 1, 1);
    issue(3, 6, 12'h222, 1, 1, "R4");
    // R9 priority cases
    issue(1, 8'h40, 12'h0, 1, 1, "R9");      // limit over everything
    issue(2, 6, 12'h0, 1, 1, "R9");          // seg right over absent
    issue(1, 7, 12'h0, 1, 1, "R9");          // page write over user
    issue(3, 4, 12'h0, 0, 1, "R9");          // seg right over absent (read)
    issue(7, 0, 12'h0, 0, 0, "R9");
    idle();

    // R10/R2: rewrite while a request is held, new entry used next cycle
    req_valid_i = 1'b1;
    req_vaddr_i = {4'd1, 8'd3, 12'hABC};
    req_write_i = 1'b0;
    req_user_i  = 1'b1;
    cur_tag = "R10";
    cfg(1, 2*256 + 3, pg_word(1, 1, 1, 12'hDEF));
    @(negedge clk_i);
    cfg(0, 1, seg_word(1, 1, 1, 2, 8'h02));
    @(negedge clk_i);
    cfg(0, 1, seg_word(0, 1, 1, 2, 8'hFF));
    @(negedge clk_i);
    idle();
    idle();

    // reset again: tables cleared
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check1("R1 rsp_valid after second reset", int'(rsp_valid_o), 0);
    issue(2, 8'h80, 12'h5, 0, 0, "R1");
    idle();
    idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule